// File: doc/BRIEF.md
# Time-Domain Pulse-Counting Multiply-Accumulate

This block forms a signed sum of products without any multiplier array. Each product is built in time. The input operand sets how long a counting window stays open: one frame of 64 cycles for each unit of input magnitude. The weight operand sets how many count-enable pulses a binary rate generator emits inside each frame. An up/down counter takes one step for each enable pulse while the window is open. The counter steps down when the input is negative. When every term has been processed, the counter holds the sum of input × weight over all terms. Zero operands cause no counter activity, so the counter's switching scales with operand magnitude.

A caller places a full set of terms on two packed vectors and pulses a start strobe. The block captures the vectors, clears the counter and walks the terms in order. It then raises a one-cycle done flag. The result stays valid until the next accepted start. The counter clamps at its signed limits instead of wrapping.

Top module: `td_mac`

## Requirements
- R1: An accepted start clears the accumulator. When done rises, the result equals the sum over all terms of signed input times weight, provided no limit is reached.
- R2: Each input is sign-magnitude. Bit 5 is the sign and bits 4:0 are the magnitude. A set sign bit makes that term count down. Negative zero contributes nothing.
- R3: Each weight is an unsigned 6-bit value. Term i occupies bits [6i+5:6i] of both the input vector and the weight vector. Term 0 is processed first.
- R4: A term with input magnitude m > 0 lasts m frames of 64 cycles, and a term with m = 0 takes one cycle. The rate generator gives exactly w enables in each frame. Done is observed T+2 cycles after the start is driven, where T is the total term time. The counter moves by at most one per cycle.
- R5: A term with zero magnitude or zero weight causes no counter step.
- R6: The accumulator saturates at +(2^(ACC_W-1)-1) and -2^(ACC_W-1) and never wraps.
- R7: Done is high for exactly one cycle. The result then holds its value until the next accepted start.
- R8: A start pulse that arrives while a computation is in progress is ignored. The vectors captured at the accepted start are the ones that are used.
- R9: After reset, done is 0 and the result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe. Accepted only when the block is idle |
| x_vec | input | N_TERMS*6 | Sign-magnitude inputs, one 6-bit field per term |
| w_vec | input | N_TERMS*6 | Unsigned weights, one 6-bit field per term |
| done | output | 1 | One-cycle flag raised after the last term |
| result | output | ACC_W | Signed accumulated sum (ACC_W = 21 by default) |

## Verification
The assertions assume that start is only acted on when the block is idle. They also assume that the operand vectors matter only at the cycle of an accepted start, so they place no stability demand on the vector ports. The bench respects the strobe contract by pulsing start for a single cycle. It deliberately re-pulses start with altered vectors during a run to confirm that the second strobe is ignored. Random operands are skewed toward zero and full-scale fields. A second instance with a narrow accumulator drives both saturation limits within a few terms.

// File: rtl/td_mac_pkg.sv
package td_mac_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/td_rate_gen.sv
// Binary rate multiplier: over 2^WT_W phases, emits exactly `weight` enables.
module td_rate_gen #(
  parameter int WT_W = 6
) (
  input  logic [WT_W-1:0] phase,
  input  logic [WT_W-1:0] weight,
  output logic            en
);
  logic [WT_W-1:0] hit;

  generate
    for (genvar j = 0; j < WT_W; j++) begin : g_slot
      localparam logic [WT_W-1:0] PAT = WT_W'((1 << j) - 1);
      // Lower j bits all ones and bit j zero: occurs 2^(WT_W-1-j) times per frame.
      assign hit[j] = (phase[j:0] == PAT[j:0]) & weight[WT_W-1-j];
    end
  endgenerate

  assign en = |hit;
endmodule

// File: rtl/td_sat_counter.sv
module td_sat_counter #(
  parameter int ACC_W = 21
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    step,
  input  logic                    down,
  output logic signed [ACC_W-1:0] count
);
  localparam logic signed [ACC_W-1:0] MAXV = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] MINV = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] ONE  = ACC_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (step) begin
      if (down) begin
        if (count != MINV) count <= count - ONE;
      end else begin
        if (count != MAXV) count <= count + ONE;
      end
    end
  end

  // R4: at most one count per cycle
  assert_unit_step_R4: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (count == $past(count) || count == $past(count) + ONE ||
              count == $past(count) - ONE));

  // R5: no enable, no movement
  assert_no_idle_step_R5: assert property (@(posedge clk) disable iff (rst)
    (!clr && !step) |=> $stable(count));

  // R6: clamp at the upper limit
  assert_hold_max_R6: assert property (@(posedge clk) disable iff (rst)
    (!clr && step && !down && count == MAXV) |=> count == MAXV);

  // R6: clamp at the lower limit
  assert_hold_min_R6: assert property (@(posedge clk) disable iff (rst)
    (!clr && step && down && count == MINV) |=> count == MINV);
endmodule

// File: rtl/td_term_seq.sv
module td_term_seq
  import td_mac_pkg::*;
#(
  parameter int N_TERMS = 8,
  parameter int X_W     = 6,
  parameter int WT_W    = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [N_TERMS*X_W-1:0]  x_vec,
  input  logic [N_TERMS*WT_W-1:0] w_vec,
  output logic [WT_W-1:0]         phase,
  output logic [WT_W-1:0]         cur_w,
  output logic                    cur_down,
  output logic                    active,
  output logic                    clr,
  output logic                    done
);
  localparam int IDX_W = (N_TERMS > 1) ? $clog2(N_TERMS) : 1;
  localparam int MAG_W = X_W - 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_TERMS - 1);

  seq_state_t               state;
  logic [N_TERMS*X_W-1:0]   xs;
  logic [N_TERMS*WT_W-1:0]  ws;
  logic [IDX_W-1:0]         idx;
  logic [MAG_W-1:0]         frame;
  logic [X_W-1:0]           cur_x;
  logic [MAG_W-1:0]         mag;
  logic                     term_end;

  assign cur_x    = xs[idx*X_W +: X_W];
  assign cur_w    = ws[idx*WT_W +: WT_W];
  assign mag      = cur_x[MAG_W-1:0];
  assign cur_down = cur_x[X_W-1];
  assign active   = (state == ST_RUN) && (mag != '0);
  assign clr      = start && (state == ST_IDLE);
  assign term_end = (mag == '0) ||
                    ((phase == '1) && (frame == mag - MAG_W'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      xs    <= '0;
      ws    <= '0;
      idx   <= '0;
      frame <= '0;
      phase <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            xs    <= x_vec;
            ws    <= w_vec;
            idx   <= '0;
            frame <= '0;
            phase <= '0;
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (term_end) begin
            phase <= '0;
            frame <= '0;
            if (idx == LAST) state <= ST_FIN;
            else             idx   <= idx + IDX_W'(1);
          end else begin
            phase <= phase + WT_W'(1);
            if (phase == '1) frame <= frame + MAG_W'(1);
          end
        end
        ST_FIN: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: done lasts one cycle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: a strobe during a run leaves the captured operands alone
  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && start) |=> ($stable(xs) && $stable(ws)));

  // R5: zero-magnitude term is skipped in one cycle
  assert_zero_mag_skip_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && mag == '0 && idx != LAST) |=> idx == $past(idx) + IDX_W'(1));

  // R3: terms advance strictly in ascending order
  assert_idx_order_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && $past(state) == ST_RUN) |->
      (idx == $past(idx) || idx == $past(idx) + IDX_W'(1)));
endmodule

// File: rtl/td_mac.sv
module td_mac #(
  parameter int N_TERMS = 8,
  parameter int X_W     = 6,
  parameter int WT_W    = 6,
  parameter int ACC_W   = 21
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [N_TERMS*X_W-1:0]  x_vec,
  input  logic [N_TERMS*WT_W-1:0] w_vec,
  output logic                    done,
  output logic signed [ACC_W-1:0] result
);
  logic [WT_W-1:0] phase;
  logic [WT_W-1:0] cur_w;
  logic            cur_down;
  logic            active;
  logic            clr;
  logic            rate_en;
  logic            step;

  td_term_seq #(
    .N_TERMS(N_TERMS),
    .X_W    (X_W),
    .WT_W   (WT_W)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .x_vec   (x_vec),
    .w_vec   (w_vec),
    .phase   (phase),
    .cur_w   (cur_w),
    .cur_down(cur_down),
    .active  (active),
    .clr     (clr),
    .done    (done)
  );

  td_rate_gen #(.WT_W(WT_W)) u_rate (
    .phase (phase),
    .weight(cur_w),
    .en    (rate_en)
  );

  assign step = active & rate_en;

  td_sat_counter #(.ACC_W(ACC_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr),
    .step (step),
    .down (cur_down),
    .count(result)
  );

  // Frame-level check of the rate generator: exactly cur_w enables per frame.
  logic [WT_W:0] frame_en_cnt;
  always_ff @(posedge clk) begin
    if (rst || phase == '1) frame_en_cnt <= '0;
    else if (active)        frame_en_cnt <= frame_en_cnt + (WT_W+1)'(rate_en);
  end

  // R4: weight sets the number of steps per frame
  assert_frame_rate_R4: assert property (@(posedge clk) disable iff (rst)
    (active && phase == '1) |-> (frame_en_cnt + (WT_W+1)'(rate_en)) == {1'b0, cur_w});

  // R5: zero weight never produces a step
  assert_zero_weight_R5: assert property (@(posedge clk) disable iff (rst)
    (active && cur_w == '0) |=> $stable(result));

  // R7: result does not move once done is raised
  assert_hold_after_done_R7: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> $stable(result));
endmodule

// File: tb/td_mac_tb.sv
module td_mac_tb;
  localparam int N  = 8;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic              start = 1'b0;
  logic [N*6-1:0]    x_vec = '0;
  logic [N*6-1:0]    w_vec = '0;
  logic              done;
  logic signed [20:0] result;

  logic              s_start = 1'b0;
  logic [NS*6-1:0]   s_x = '0;
  logic [NS*6-1:0]   s_w = '0;
  logic              s_done;
  logic signed [11:0] s_result;

  td_mac #(.N_TERMS(N), .ACC_W(21)) u_dut (
    .clk(clk), .rst(rst), .start(start), .x_vec(x_vec), .w_vec(w_vec),
    .done(done), .result(result)
  );

  td_mac #(.N_TERMS(NS), .ACC_W(12)) u_sat (
    .clk(clk), .rst(rst), .start(s_start), .x_vec(s_x), .w_vec(s_w),
    .done(s_done), .result(s_result)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      $display("FAIL watchdog: run did not finish, actual cycles=%0d expected<190000", cyc);
      fails  = fails + 1;
      checks = checks + 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint ref_sum(input logic [47:0] xv, input logic [47:0] wv,
                                     input int n, input int accw);
    longint acc = 0;
    longint hi = (longint'(1) << (accw - 1)) - 1;
    longint lo = -(longint'(1) << (accw - 1));
    for (int i = 0; i < n; i++) begin
      longint m = xv[i*6 +: 5];
      longint w = wv[i*6 +: 6];
      acc = xv[i*6+5] ? acc - m * w : acc + m * w;
      if (acc > hi) acc = hi;
      if (acc < lo) acc = lo;
    end
    return acc;
  endfunction

  function automatic int ref_time(input logic [47:0] xv, input int n);
    int t = 0;
    for (int i = 0; i < n; i++) begin
      int m = xv[i*6 +: 5];
      t += (m == 0) ? 1 : m * 64;
    end
    return t;
  endfunction

  function automatic logic [5:0] rnd_field(input bit is_x);
    int sel = $urandom % 8;
    logic [5:0] v = 6'($urandom);
    if (sel == 0) v = is_x ? {v[5], 5'd0} : 6'd0;
    else if (sel == 1) v = is_x ? {v[5], 5'd31} : 6'd63;
    return v;
  endfunction

  task automatic run_main(input logic [47:0] xv, input logic [47:0] wv,
                          input bit poke, input string tag);
    int cnt = 1;
    longint exp_r = ref_sum(xv, wv, N, 21);
    int exp_t = ref_time(xv, N) + 2;
    @(negedge clk);
    x_vec = xv; w_vec = wv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cnt < 20000) begin
      @(negedge clk);
      cnt++;
      if (poke && cnt == 50) begin
        start = 1'b1; x_vec = ~xv; w_vec = ~wv;
      end
      if (poke && cnt == 51) start = 1'b0;
    end
    check({tag, " R1 sum"}, longint'(result), exp_r);
    check({tag, " R4 latency"}, cnt, exp_t);
    @(negedge clk);
    check({tag, " R7 done pulse"}, done, 0);
    repeat (5) @(negedge clk);
    check({tag, " R7 result held"}, longint'(result), exp_r);
  endtask

  task automatic run_sat(input logic [23:0] xv, input logic [23:0] wv, input string tag);
    int cnt = 1;
    longint exp_r = ref_sum({24'd0, xv}, {24'd0, wv}, NS, 12);
    @(negedge clk);
    s_x = xv; s_w = wv; s_start = 1'b1;
    @(negedge clk);
    s_start = 1'b0;
    while (!s_done && cnt < 20000) begin
      @(negedge clk);
      cnt++;
    end
    check({tag, " R6 saturated sum"}, longint'(s_result), exp_r);
  endtask

  initial begin
    logic [47:0] xv;
    logic [47:0] wv;
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 reset done", done, 0);
    check("R9 reset result", longint'(result), 0);

    // R5: all-zero operands and zero weights
    run_main(48'd0, {8{6'd63}}, 1'b0, "R5 zero-x");
    run_main({8{6'd31}}, 48'd0, 1'b0, "R5 zero-w");
    // R2: negative zero contributes nothing
    run_main({8{6'b100000}}, {8{6'd63}}, 1'b0, "R2 neg-zero");
    // R1/R2 extremes
    run_main({8{6'd31}}, {8{6'd63}}, 1'b0, "R1 max-pos");
    run_main({8{6'b111111}}, {8{6'd63}}, 1'b0, "R2 max-neg");
    // R3: distinct per-term fields, mixed signs
    for (int i = 0; i < N; i++) begin
      xv[i*6 +: 6] = {i[0], 5'(i + 1)};
      wv[i*6 +: 6] = 6'(7 * i + 3);
    end
    run_main(xv, wv, 1'b0, "R3 field order");
    // R8: start while busy is ignored
    run_main({8{6'd2}}, {8{6'd17}}, 1'b1, "R8 busy start");

    // R1: constrained random
    for (int r = 0; r < 5; r++) begin
      for (int i = 0; i < N; i++) begin
        xv[i*6 +: 6] = rnd_field(1'b1);
        wv[i*6 +: 6] = rnd_field(1'b0);
      end
      run_main(xv, wv, 1'b0, "R1 random");
    end

    // R6: narrow accumulator (12 bits: +2047 / -2048)
    run_sat({4{6'd31}}, {4{6'd63}}, "R6 upper");
    run_sat({4{6'b111111}}, {4{6'd63}}, "R6 lower");
    run_sat({6'b111111, 6'b111111, 6'd31, 6'd31}, {4{6'd63}}, "R6 up-then-down");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule